// File: doc/BRIEF.md
# Automatic Flash Status Polling Unit

This unit sits beside the command-phase sequencer of a serial-flash engine and repeats a status-read command on its own, so that software does not have to spin on a flash busy bit. Each time the sequencer hands back a status word, the unit compares it against a bitwise mask and an expected value. When every masked bit agrees, the unit sets a sticky match flag. It can also raise an interrupt if that is enabled.

A poll session starts when a command is launched with the functional mode field set to the auto-poll encoding. The unit then alternates between two activities. It asks the sequencer for a status read, and between reads it waits a programmable number of serial-clock ticks. It either stops on the first match and reports the command complete, or it keeps polling until software aborts. The status word is one to four bytes wide, and only the bytes inside the programmed length take part in the compare. Timeouts are left to software.

Top module: `qspi_autopoll`

## Requirements
- R1: A session starts only when `cmd_start` is high, `abort` is low and `func_mode` equals 2'b10 while the unit is idle. Any other mode value leaves `busy` and `status_req` low.
- R2: The cycle after an accepted start, `status_req` is high for exactly one cycle. The unit then waits for `status_valid` before doing anything else.
- R3: A returned word is a hit when, for every byte lane i with i <= `len_m1`, `((status_data ^ match_val) & mask)` is zero in bits [8i+7:8i]. Byte lanes above `len_m1` are ignored.
- R4: A hit sets `match_flag` on the clock edge that samples `status_valid`. A high `flag_clr` with no hit in the same cycle clears it. A hit and a clear in the same cycle leave the flag set.
- R5: `irq` is high exactly when `match_flag` and `match_ie` are both high.
- R6: With `stop_on_match` high, a hit ends the session. `busy` drops and `cmd_done` pulses for one cycle, both starting the cycle after `status_valid`.
- R7: With `stop_on_match` low, a hit does not end the session, polling goes on, and `cmd_done` never pulses.
- R8: After a read that does not end the session, the unit counts `interval` pulses of `sck_tick`. Once the count is exhausted it raises `status_req` again on the following cycle. With `interval` equal to 0, the next request comes two cycles after `status_valid`.
- R9: `abort` ends an active session on the next edge from any state, without a `cmd_done` pulse. A `status_valid` that arrives in the same cycle as `abort` neither sets the flag nor counts as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Command launch pulse |
| func_mode | input | 2 | Functional mode of the launched command; 2'b10 selects auto-poll |
| stop_on_match | input | 1 | End the session on the first hit |
| match_ie | input | 1 | Match interrupt enable |
| abort | input | 1 | Abort request |
| flag_clr | input | 1 | Write-1-to-clear strobe for the match flag |
| mask | input | 32 | Per-bit compare enable |
| match_val | input | 32 | Expected status bit values |
| interval | input | 16 | Serial-clock ticks between status reads |
| len_m1 | input | 2 | Status length in bytes minus one |
| sck_tick | input | 1 | One pulse per serial clock period |
| status_valid | input | 1 | Sequencer returns a status word |
| status_data | input | 32 | Returned status word, byte 0 in bits [7:0] |
| status_req | output | 1 | Request to the sequencer for one status read |
| busy | output | 1 | Session active |
| match_flag | output | 1 | Sticky status-match flag |
| irq | output | 1 | Match interrupt |
| cmd_done | output | 1 | One-cycle completion pulse for a stop-on-match session |

## Verification
The hardest situation to reach is an abort that lands in the very cycle in which the sequencer returns a matching word, because the two events come from unrelated agents. The bench's status responder has a switch that raises abort together with the returned word. This shows that the flag stays clear and no completion is reported. Set-versus-clear collisions on the flag are reached by holding the clear strobe high through a continuous polling run with frequent hits. Interval counting is exercised both with a serial tick every cycle and with a tick on every other cycle, and also with a zero interval.

// File: rtl/qspi_apm_pkg.sv
// Package: shared encodings for the automatic status polling unit.
// Assumes the command configuration functional-mode field is two bits wide.
package qspi_apm_pkg;

    // Functional mode value that selects automatic polling
    localparam logic [1:0] FMODE_AUTOPOLL = 2'b10;

    // Session state
    typedef enum logic [1:0] {
        APM_IDLE = 2'd0,
        APM_REQ  = 2'd1,
        APM_WAIT = 2'd2,
        APM_GAP  = 2'd3
    } apm_state_t;

endpackage

// File: rtl/apm_status_cmp.sv
// Module: masked status comparator.
// Splits the status word into byte lanes. A lane takes part only if its
// index is within the programmed length. Every enabled lane must agree on
// all masked bits for a hit. Purely combinational.
module apm_status_cmp #(
    parameter int NBYTES = 4,
    localparam int SW    = 8 * NBYTES,
    localparam int LW    = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic [SW-1:0] data,
    input  logic [SW-1:0] expect_val,
    input  logic [SW-1:0] bit_en,
    input  logic [LW-1:0] len_m1,
    output logic          hit
);

    logic [NBYTES-1:0] lane_ok;

    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        logic [7:0] diff;
        logic       used;
        // Per-lane difference limited to masked bits
        always_comb begin
            diff       = (data[8*i +: 8] ^ expect_val[8*i +: 8]) & bit_en[8*i +: 8];
            used       = (LW'(i) <= len_m1);
            lane_ok[i] = !used || (diff == 8'h00);
        end
    end

    // Hit when all lanes agree
    assign hit = &lane_ok;

endmodule

// File: rtl/apm_gap_timer.sv
// Module: inter-poll interval counter.
// Loaded with the interval on each non-terminal read. Counts down on
// serial-clock ticks and reports expiry once the count reaches zero.
module apm_gap_timer #(
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [IW-1:0] load_val,
    input  logic          run,
    input  logic          tick,
    output logic          expired
);

    logic [IW-1:0] cnt_q;

    // Load on request, otherwise decrement on tick while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/apm_match_flag.sv
// Module: sticky match flag with write-1-to-clear and interrupt gating.
// A set and a clear in the same cycle leave the flag set, so no match is lost.
module apm_match_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic ie,
    output logic flag,
    output logic irq
);

    logic flag_q;

    // Flag register: set dominates clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;
    assign irq  = flag_q && ie;

endmodule

// File: rtl/qspi_autopoll.sv
// Module: automatic flash status polling unit (top).
// Runs a session of repeated status reads through the shared command
// sequencer (status_req / status_valid handshake). Each returned word goes
// to the comparator. A hit sets the match flag. The session either ends on
// the first hit or keeps polling until abort. Assumes the sequencer answers
// each request with exactly one status_valid pulse.
module qspi_autopoll #(
    parameter int STAT_BYTES = 4,
    parameter int IVL_W      = 16,
    localparam int SW        = 8 * STAT_BYTES,
    localparam int LW        = (STAT_BYTES > 1) ? $clog2(STAT_BYTES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_start,
    input  logic [1:0]    func_mode,
    input  logic          stop_on_match,
    input  logic          match_ie,
    input  logic          abort,
    input  logic          flag_clr,
    input  logic [SW-1:0] mask,
    input  logic [SW-1:0] match_val,
    input  logic [IVL_W-1:0] interval,
    input  logic [LW-1:0] len_m1,
    input  logic          sck_tick,
    input  logic          status_valid,
    input  logic [SW-1:0] status_data,
    output logic          status_req,
    output logic          busy,
    output logic          match_flag,
    output logic          irq,
    output logic          cmd_done
);
    import qspi_apm_pkg::*;

    apm_state_t state_q, state_d;
    logic       hit;
    logic       take_word;
    logic       word_hit;
    logic       gap_load;
    logic       gap_expired;
    logic       done_q;

    // Status compare
    apm_status_cmp #(.NBYTES(STAT_BYTES)) u_cmp (
        .data       (status_data),
        .expect_val (match_val),
        .bit_en     (mask),
        .len_m1     (len_m1),
        .hit        (hit)
    );

    // A returned word counts only while waiting and not aborted
    assign take_word = (state_q == APM_WAIT) && status_valid && !abort;
    assign word_hit  = take_word && hit;
    assign gap_load  = take_word && !(hit && stop_on_match);

    // Interval timer between reads
    apm_gap_timer #(.IW(IVL_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (interval),
        .run      (state_q == APM_GAP),
        .tick     (sck_tick),
        .expired  (gap_expired)
    );

    // Match flag and interrupt
    apm_match_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (word_hit),
        .clr   (flag_clr),
        .ie    (match_ie),
        .flag  (match_flag),
        .irq   (irq)
    );

    // Next-state decision for the polling session
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            APM_IDLE: if (cmd_start && !abort && func_mode == FMODE_AUTOPOLL) state_d = APM_REQ;
            APM_REQ:  state_d = abort ? APM_IDLE : APM_WAIT;
            APM_WAIT: begin
                if (abort)                        state_d = APM_IDLE;
                else if (word_hit && stop_on_match) state_d = APM_IDLE;
                else if (take_word)               state_d = APM_GAP;
            end
            APM_GAP: begin
                if (abort)            state_d = APM_IDLE;
                else if (gap_expired) state_d = APM_REQ;
            end
            default: state_d = APM_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= APM_IDLE;
        else        state_q <= state_d;
    end

    // Completion pulse on a terminating hit
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= word_hit && stop_on_match;
    end

    assign status_req = (state_q == APM_REQ);
    assign busy       = (state_q != APM_IDLE);
    assign cmd_done   = done_q;

endmodule

// File: rtl/qspi_autopoll_chk.sv
// Module: protocol checker for the polling unit, bound to the top.
// Observes ports only.
module qspi_autopoll_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_start,
    input logic [1:0] func_mode,
    input logic       abort,
    input logic       flag_clr,
    input logic       status_valid,
    input logic       status_req,
    input logic       busy,
    input logic       match_flag,
    input logic       match_ie,
    input logic       irq,
    input logic       cmd_done
);

    p_idle_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_start && func_mode != 2'b10) |=> !busy);

    p_req_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        status_req |=> !status_req);

    p_flag_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_flag) |-> $past(status_valid));

    p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag && flag_clr && !status_valid) |=> !match_flag);

    p_irq_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (match_flag && match_ie));

    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> (!busy && $past(status_valid)));

    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort) |=> (!busy && !cmd_done));

endmodule

bind qspi_autopoll qspi_autopoll_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_start    (cmd_start),
    .func_mode    (func_mode),
    .abort        (abort),
    .flag_clr     (flag_clr),
    .status_valid (status_valid),
    .status_req   (status_req),
    .busy         (busy),
    .match_flag   (match_flag),
    .match_ie     (match_ie),
    .irq          (irq),
    .cmd_done     (cmd_done)
);

// File: tb/test_qspi_autopoll.sv
`timescale 1ns/1ps
module test_qspi_autopoll;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [1:0]  func_mode = 2'b00;
    logic        stop_on_match = 1'b0;
    logic        match_ie = 1'b0;
    logic        abort_m = 1'b0;
    logic        abort_r = 1'b0;
    logic        abort;
    logic        flag_clr = 1'b0;
    logic [31:0] mask = '0;
    logic [31:0] match_val = '0;
    logic [15:0] interval = '0;
    logic [1:0]  len_m1 = '0;
    logic        sck_tick = 1'b0;
    logic        status_valid = 1'b0;
    logic [31:0] status_data = '0;
    logic        status_req, busy, match_flag, irq, cmd_done;

    int checks = 0;
    int fails = 0;
    int tick_div = 1;
    int tick_cnt = 0;
    int pend = 0;
    bit abort_on_valid = 1'b0;
    logic [31:0] rq[$];

    assign abort = abort_m | abort_r;

    always #2.5 clk = ~clk;   // 200 MHz

    qspi_autopoll i_qspi_autopoll (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .func_mode(func_mode),
        .stop_on_match(stop_on_match), .match_ie(match_ie), .abort(abort),
        .flag_clr(flag_clr), .mask(mask), .match_val(match_val),
        .interval(interval), .len_m1(len_m1), .sck_tick(sck_tick),
        .status_valid(status_valid), .status_data(status_data),
        .status_req(status_req), .busy(busy), .match_flag(match_flag),
        .irq(irq), .cmd_done(cmd_done)
    );

    // ---------------- reference model ----------------
    int m_st = 0;          // 0 idle, 1 request, 2 waiting, 3 gap
    int m_cnt = 0;
    bit m_flag = 0;
    bit m_done = 0;

    function automatic bit ref_hit(logic [31:0] d);
        for (int b = 0; b < 4; b++) begin
            if (b <= int'(len_m1)) begin
                if ((((d >> (8*b)) ^ (match_val >> (8*b))) & (mask >> (8*b)) & 32'hFF) != 0)
                    return 1'b0;
            end
        end
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        bit h;
        bit set;
        set = 1'b0;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_flag = 0; m_done = 0;
        end else begin
            m_done = 0;
            case (m_st)
                0: if (cmd_start && !abort && func_mode == 2'b10) m_st = 1;
                1: m_st = abort ? 0 : 2;
                2: if (abort) m_st = 0;
                   else if (status_valid) begin
                       h = ref_hit(status_data);
                       set = h;
                       if (h && stop_on_match) begin m_st = 0; m_done = 1; end
                       else begin m_st = 3; m_cnt = int'(interval); end
                   end
                default: if (abort) m_st = 0;
                         else if (m_cnt == 0) m_st = 1;
                         else if (sck_tick) m_cnt--;
            endcase
            if (set) m_flag = 1;
            else if (flag_clr) m_flag = 0;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison, 1 ns after the active edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            check("R2 R8 status_req", status_req, m_st == 1);
            check("R1 R6 R7 R9 busy", busy, m_st != 0);
            check("R3 R4 match_flag", match_flag, m_flag);
            check("R5 irq", irq, m_flag && match_ie);
            check("R6 R7 R9 cmd_done", cmd_done, m_done);
        end
    end

    // Serial tick generator and status responder
    always @(negedge clk) begin
        tick_cnt++;
        sck_tick = (tick_cnt % tick_div) == 0;
        status_valid = 1'b0;
        abort_r = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                status_valid = 1'b1;
                status_data = (rq.size() > 0) ? rq.pop_front() : 32'hFFFF_FFFF;
                if (abort_on_valid) abort_r = 1'b1;
            end
        end else if (status_req) begin
            pend = 2;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start(input logic [1:0] mode);
        @(negedge clk); func_mode = mode; cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
    endtask

    task automatic do_abort();
        @(negedge clk); abort_m = 1'b1;
        @(negedge clk); abort_m = 1'b0;
        cyc(3); rq.delete();
    endtask

    task automatic wait_idle(input int lim);
        for (int i = 0; i < lim && busy; i++) @(negedge clk);
    endtask

    task automatic run_all();
        cyc(3); rst_n = 1'b1; cyc(2);
        check("R1 reset busy", busy, 1'b0);
        check("R4 reset flag", match_flag, 1'b0);

        // R1: wrong mode ignored
        start(2'b01); cyc(6);
        check("R1 mode 01 ignored", busy, 1'b0);
        start(2'b11); cyc(6);
        check("R1 mode 11 ignored", busy, 1'b0);

        // R6 R8 R3: stop on match, single byte, interval 3
        stop_on_match = 1; match_ie = 1; mask = 32'h0000_00C0; match_val = 32'h40;
        len_m1 = 0; interval = 3; tick_div = 1;
        rq.push_back(32'h00); rq.push_back(32'h80); rq.push_back(32'h4F);
        start(2'b10); wait_idle(200); cyc(2);
        check("R6 session ended", busy, 1'b0);
        check("R5 irq after hit", irq, 1'b1);
        @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0; cyc(1);
        check("R4 flag cleared", match_flag, 1'b0);

        // R3: upper byte lanes ignored, two-byte length
        mask = 32'hFFFF_FFFF; match_val = 32'h0000_1234; len_m1 = 1; interval = 2;
        rq.push_back(32'h0000_1334); rq.push_back(32'hAB00_1234);
        start(2'b10); wait_idle(200); cyc(2);
        check("R3 lanes above length ignored", match_flag, 1'b1);

        // R7 R4: continuous polling, clear held, slower tick
        stop_on_match = 0; match_ie = 0; len_m1 = 3; interval = 5; tick_div = 2;
        match_val = 32'hA5A5_0000; mask = 32'hFFFF_0000;
        for (int i = 0; i < 12; i++) rq.push_back((i % 2) ? 32'hA5A5_1111 : 32'h0000_0000);
        start(2'b10);
        cyc(40); flag_clr = 1; cyc(60); flag_clr = 0; cyc(40);
        check("R7 still polling", busy, 1'b1);
        do_abort();
        check("R9 abort ends gap/wait", busy, 1'b0);

        // R8: zero interval
        interval = 0; tick_div = 1;
        start(2'b10); cyc(30); do_abort();

        // R9: abort coincident with a hit
        @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0;
        stop_on_match = 1; abort_on_valid = 1;
        rq.push_back(32'hA5A5_0000);
        start(2'b10); cyc(10);
        check("R9 aborted hit not flagged", match_flag, 1'b0);
        check("R9 aborted session idle", busy, 1'b0);
        abort_on_valid = 0; rq.delete();

        // R9: abort right after the request
        start(2'b10); abort_m = 1; @(negedge clk); abort_m = 0; cyc(6);
        check("R9 abort in request", busy, 1'b0);
        cyc(5);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                fails++;
                $display("FAIL watchdog all requirements actual=hung expected=finished");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule